// File: doc/BRIEF.md
# Out-of-Order Instruction Queue with Three-Way Dispatch

This block sits between an instruction fetch path and three execution units: integer, floating point and branch. It asks the fetch path for a block of eight instructions whenever the queue has room for a whole block, and stores the block in program order. Each cycle it scans every queued entry. It sorts the entries by class and checks each one against a register scoreboard and against all older entries still waiting in the queue. For each unit it then offers the oldest entry that is safe to start.

A younger entry that has no dependence on a stalled older one may leave first, so one blocked instruction does not hold up the others. An entry leaves the queue on a valid/ready handshake, and the remaining entries close up behind it in order. A writer that issues marks its destination register busy. A completion pulse that names the register clears the mark. A flush input discards the whole queue and cancels a fetch request that is still open.

Top module: `iq_dispatch`

## Requirements
- R1: After reset the queue is empty, no fetch request is open, every register is free, all three issue valids are low and `fetch_req` is high.
- R2: `fetch_req` is high in a cycle exactly when no request is open, at least eight slots are free and `flush` is low. A cycle with `fetch_req` high opens a request.
- R3: `fill_valid` is taken only while a request is open, and taking it closes the request. The eight instructions are appended in order, with element 0 (bits 17:0 of `fill_blk`) oldest. A fill that arrives with no open request leaves the queue unchanged.
- R4: An instruction is 18 bits: class [17:16], write flag [15], destination [14:10], source A [9:5], source B [4:0]. Class 00 goes only to the integer port, 01 only to the floating-point port, and 10 or 11 only to the branch port.
- R5: Each port offers at most one entry per cycle, and it is the oldest eligible entry of that class. The entry leaves the queue on the edge where valid and ready are both high. Otherwise it is offered again.
- R6: An entry is held back while either of its sources is marked busy, or while an older queued entry writes one of its sources.
- R7: A writing entry is held back while its destination is busy, or while an older queued entry reads or writes that destination.
- R8: An eligible younger entry of a class is offered even while an older entry of the same class is held back.
- R9: A writing entry marks its destination busy on its issue edge. A completion pulse clears the named register on its edge. Both changes are seen from the next cycle on.
- R10: While `flush` is high, all issue valids and `fetch_req` are low. On the next cycle the queue is empty and no request is open. The scoreboard is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard queue and open request |
| fetch_req | output | 1 | Ask for one eight-instruction block |
| fill_valid | input | 1 | Block present on `fill_blk` |
| fill_blk | input | 144 | Eight instructions, element 0 in the low bits |
| iss_valid | output | 3 | Offer per unit: bit0 integer, bit1 float, bit2 branch |
| iss_ready | input | 3 | Unit accepts the offer, same bit order |
| iss_int | output | 18 | Instruction offered to the integer unit |
| iss_fp | output | 18 | Instruction offered to the floating-point unit |
| iss_br | output | 18 | Instruction offered to the branch unit |
| cmp_valid | input | 3 | Completion pulse per unit |
| cmp_reg | input | 15 | Register freed per pulse, 5 bits each, unit 0 lowest |

## Verification
Two cases can land on the same edge, and the bench provokes both. In the first, a block fill and up to three issue handshakes occur together, so the compacted survivors and the appended block must end up in one ordered queue. In the second, a completion pulse clears a register while another writer issues. Random instructions use only eight registers, so hazards and overtaking are frequent. Ready and completion inputs are random, so all of these events regularly fall in the same cycle. A bench model built from the requirements predicts every port on every cycle. Directed steps pin down hold, overtaking and unblock on a known block.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int REG_W  = 5;
    localparam int N_UNIT = 3;

    typedef struct packed {
        logic [1:0]       cls;
        logic             wr;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    // class 00 -> integer, 01 -> float, 1x -> branch
    function automatic logic [1:0] unit_of(logic [1:0] cls);
        return cls[1] ? 2'd2 : {1'b0, cls[0]};
    endfunction
endpackage

// File: rtl/iq_pick.sv
module iq_pick #(
    parameter int  DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] elig,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);
    // lowest index is oldest; scan downward so the oldest wins
    always_comb begin
        vld = |elig;
        idx = '0;
        for (int j = DEPTH - 1; j >= 0; j--) begin
            if (elig[j]) idx = IDX_W'(j);
        end
    end
endmodule

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
    parameter int  NREG  = 32,
    parameter int  NPORT = 3,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         set_vld,
    input  logic [NPORT-1:0][RW-1:0] set_reg,
    input  logic [NPORT-1:0]         clr_vld,
    input  logic [NPORT-1:0][RW-1:0] clr_reg,
    output logic [NREG-1:0]          busy
);
    typedef struct packed {
        logic [NREG-1:0] busy;
    } sb_t;

    sb_t sb_q, sb_d;

    always_comb begin
        sb_d = sb_q;
        for (int i = 0; i < NPORT; i++) begin
            if (clr_vld[i]) sb_d.busy[clr_reg[i]] = 1'b0;
        end
        // a new writer takes precedence over a clear in the same cycle
        for (int i = 0; i < NPORT; i++) begin
            if (set_vld[i]) sb_d.busy[set_reg[i]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign busy = sb_q.busy;

    logic [NPORT-1:0] clr_alone;
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            clr_alone[i] = clr_vld[i];
            for (int k = 0; k < NPORT; k++) begin
                if (set_vld[k] && set_reg[k] == clr_reg[i]) clr_alone[i] = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vld[i] |=> busy[$past(set_reg[i])]);                 // R9
        AST_CLR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            clr_alone[i] |=> !busy[$past(clr_reg[i])]);              // R9
    end
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BLK   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    output logic                      fetch_req,
    input  logic                      fill_valid,
    input  logic [BLK*INSTR_W-1:0]    fill_blk,
    output logic [N_UNIT-1:0]         iss_valid,
    input  logic [N_UNIT-1:0]         iss_ready,
    output logic [INSTR_W-1:0]        iss_int,
    output logic [INSTR_W-1:0]        iss_fp,
    output logic [INSTR_W-1:0]        iss_br,
    input  logic [N_UNIT-1:0]         cmp_valid,
    input  logic [N_UNIT*REG_W-1:0]   cmp_reg
);
    localparam int NREG  = 1 << REG_W;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        instr_t [DEPTH-1:0] ent;
        logic   [CNT_W-1:0] cnt;
        logic               pend;
    } st_t;

    st_t st_q, st_d;

    logic [NREG-1:0]                  busy;
    logic [N_UNIT-1:0][DEPTH-1:0]     elig;
    logic [N_UNIT-1:0]                pk_vld;
    logic [N_UNIT-1:0][IDX_W-1:0]     pk_idx;
    instr_t [N_UNIT-1:0]              sel;
    logic [N_UNIT-1:0]                fire;
    logic [N_UNIT-1:0]                set_vld;
    logic [N_UNIT-1:0][REG_W-1:0]     set_reg;
    logic [N_UNIT-1:0][REG_W-1:0]     clr_reg;

    assign clr_reg = cmp_reg;

    iq_scoreboard #(.NREG(NREG), .NPORT(N_UNIT)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (set_vld),
        .set_reg (set_reg),
        .clr_vld (cmp_valid),
        .clr_reg (clr_reg),
        .busy    (busy)
    );

    // hazard scan: each live entry against scoreboard and older entries
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            instr_t e;
            logic   blk;
            e   = st_q.ent[j];
            blk = busy[e.src_a] || busy[e.src_b] || (e.wr && busy[e.dst]);
            for (int k = 0; k < j; k++) begin
                instr_t o;
                o = st_q.ent[k];
                if (o.wr && (o.dst == e.src_a || o.dst == e.src_b ||
                             (e.wr && o.dst == e.dst))) blk = 1'b1;
                if (e.wr && (o.src_a == e.dst || o.src_b == e.dst)) blk = 1'b1;
            end
            for (int u = 0; u < N_UNIT; u++) begin
                elig[u][j] = (j < int'(st_q.cnt)) && !blk && (unit_of(e.cls) == 2'(u));
            end
        end
    end

    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
        iq_pick #(.DEPTH(DEPTH)) u_pick (
            .elig (elig[u]),
            .vld  (pk_vld[u]),
            .idx  (pk_idx[u])
        );
    end

    always_comb begin
        for (int u = 0; u < N_UNIT; u++) begin
            sel[u]     = st_q.ent[pk_idx[u]];
            set_vld[u] = fire[u] && sel[u].wr;
            set_reg[u] = sel[u].dst;
        end
    end

    assign iss_valid = pk_vld & {N_UNIT{!flush}};
    assign fire      = iss_valid & iss_ready;
    assign iss_int   = sel[0];
    assign iss_fp    = sel[1];
    assign iss_br    = sel[2];
    assign fetch_req = !st_q.pend && !flush && (int'(st_q.cnt) + BLK <= DEPTH);

    // next state: compact survivors, append fill, track request
    always_comb begin
        int n;
        st_d = st_q;
        n    = 0;
        for (int j = 0; j < DEPTH; j++) begin
            logic gone;
            gone = 1'b0;
            for (int u = 0; u < N_UNIT; u++) begin
                if (fire[u] && int'(pk_idx[u]) == j) gone = 1'b1;
            end
            if (j < int'(st_q.cnt) && !gone) begin
                st_d.ent[IDX_W'(n)] = st_q.ent[j];
                n = n + 1;
            end
        end
        if (st_q.pend && fill_valid) begin
            for (int b = 0; b < BLK; b++) begin
                if (n + b < DEPTH) st_d.ent[IDX_W'(n + b)] = fill_blk[b*INSTR_W +: INSTR_W];
            end
            n         = n + BLK;
            st_d.pend = 1'b0;
        end
        if (fetch_req) st_d.pend = 1'b1;
        st_d.cnt = CNT_W'(n);
        if (flush) begin
            st_d.cnt  = '0;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= DEPTH);                                        // R3
    AST_PEND_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (int'(st_q.cnt) + BLK <= DEPTH));                  // R2
    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && fill_valid && !flush) |=> (int'(st_q.cnt) >= BLK)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0 && !st_q.pend));                       // R10
    for (genvar u = 0; u < N_UNIT; u++) begin : g_chk
        AST_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[u] |-> (!busy[sel[u].src_a] && !busy[sel[u].src_b])); // R6
        AST_UNIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[u] |-> (unit_of(sel[u].cls) == 2'(u)));          // R4
    end
endmodule

// File: tb/sim_iq_dispatch.sv
module sim_iq_dispatch;
    import iq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 flush = 1'b0;
    logic                 fetch_req;
    logic                 fill_valid = 1'b0;
    logic [8*INSTR_W-1:0] fill_blk = '0;
    logic [2:0]           iss_valid;
    logic [2:0]           iss_ready = 3'b000;
    logic [INSTR_W-1:0]   iss_int, iss_fp, iss_br;
    logic [2:0]           cmp_valid = 3'b000;
    logic [3*REG_W-1:0]   cmp_reg = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    instr_t    mq[$];
    bit [31:0] msb = '0;
    bit        mpend = 1'b0;

    always #4 clk = ~clk;

    iq_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
        .fill_valid(fill_valid), .fill_blk(fill_blk), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_int(iss_int), .iss_fp(iss_fp), .iss_br(iss_br),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int b_unit(instr_t i);
        return (i.cls >= 2'd2) ? 2 : int'(i.cls);
    endfunction

    function automatic bit m_blocked(int j);
        instr_t e = mq[j];
        if (msb[e.src_a] || msb[e.src_b] || (e.wr && msb[e.dst])) return 1'b1;
        for (int k = 0; k < j; k++) begin
            instr_t o = mq[k];
            if (o.wr && (o.dst == e.src_a || o.dst == e.src_b || (e.wr && o.dst == e.dst))) return 1'b1;
            if (e.wr && (o.src_a == e.dst || o.src_b == e.dst)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int m_pick(int u);
        for (int j = 0; j < mq.size(); j++) begin
            if (b_unit(mq[j]) == u && !m_blocked(j)) return j;
        end
        return -1;
    endfunction

    function automatic logic [INSTR_W-1:0] port_of(int u);
        return (u == 0) ? iss_int : (u == 1) ? iss_fp : iss_br;
    endfunction

    function automatic instr_t mk(logic [1:0] c, logic w, int d, int a, int b);
        instr_t i;
        i.cls = c; i.wr = w; i.dst = REG_W'(d); i.src_a = REG_W'(a); i.src_b = REG_W'(b);
        return i;
    endfunction

    function automatic instr_t rnd_instr();
        return mk(2'($urandom % 4), ($urandom % 4) != 0, $urandom % 8, $urandom % 8, $urandom % 8);
    endfunction

    // drive at a negedge, check the model, advance the model, end at next negedge
    task automatic step(input bit fl, input bit fv, input logic [8*INSTR_W-1:0] blk,
                        input logic [2:0] rdy, input logic [2:0] cv, input logic [3*REG_W-1:0] cr);
        int p[3];
        bit exp_req;
        bit [31:0] nsb;
        bit rm[$];
        flush = fl; fill_valid = fv; fill_blk = blk; iss_ready = rdy;
        cmp_valid = cv; cmp_reg = cr;
        #1;
        for (int u = 0; u < 3; u++) begin
            p[u] = fl ? -1 : m_pick(u);
            chk(iss_valid[u] == (p[u] >= 0), "R5/R6/R7 valid", iss_valid[u], p[u] >= 0);
            if (p[u] >= 0)
                chk(port_of(u) == mq[p[u]], "R4/R5 instr", port_of(u), mq[p[u]]);
        end
        exp_req = !mpend && !fl && (mq.size() + 8 <= 16);
        chk(fetch_req == exp_req, "R2 fetch_req", fetch_req, exp_req);
        nsb = msb;
        for (int i = 0; i < 3; i++) if (cv[i]) nsb[cr[i*REG_W +: REG_W]] = 1'b0;
        for (int j = 0; j < mq.size(); j++) rm.push_back(1'b0);
        for (int u = 0; u < 3; u++) begin
            if (p[u] >= 0 && rdy[u]) begin
                if (mq[p[u]].wr) nsb[mq[p[u]].dst] = 1'b1;
                rm[p[u]] = 1'b1;
            end
        end
        if (fl) begin
            mq.delete();
            mpend = 1'b0;
        end else begin
            for (int j = mq.size() - 1; j >= 0; j--) if (rm[j]) mq.delete(j);
            if (mpend && fv) begin
                for (int b = 0; b < 8; b++) mq.push_back(instr_t'(blk[b*INSTR_W +: INSTR_W]));
                mpend = 1'b0;
            end
            if (exp_req) mpend = 1'b1;
        end
        msb = nsb;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [8*INSTR_W-1:0] blk_a;
        instr_t a[8];
        void'($urandom(32'd20240611));
        a[0] = mk(2'b00, 1'b1, 1, 2, 3);
        a[1] = mk(2'b00, 1'b1, 4, 1, 1);
        a[2] = mk(2'b00, 1'b1, 5, 6, 6);
        a[3] = mk(2'b01, 1'b1, 2, 7, 7);
        a[4] = mk(2'b10, 1'b0, 0, 6, 6);
        a[5] = mk(2'b11, 1'b0, 0, 0, 0);
        a[6] = mk(2'b01, 1'b1, 3, 3, 3);
        a[7] = mk(2'b00, 1'b1, 7, 7, 7);
        for (int b = 0; b < 8; b++) blk_a[b*INSTR_W +: INSTR_W] = a[b];

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(iss_valid == 3'b000, "R1 reset valids", iss_valid, 0);
        chk(fetch_req == 1'b1, "R1 reset fetch_req", fetch_req, 1);

        // flush with a stray fill, then a stray fill with no open request
        step(1'b1, 1'b1, blk_a, 3'b111, 3'b000, '0);
        step(1'b0, 1'b1, blk_a, 3'b111, 3'b000, '0);
        chk(iss_valid == 3'b000, "R3/R10 stray fill ignored", iss_valid, 0);

        // accepted fill, nothing ready
        step(1'b0, 1'b1, blk_a, 3'b000, 3'b000, '0);
        chk(iss_int == a[0], "R5 oldest integer", iss_int, a[0]);
        chk(iss_valid[1] == 1'b0, "R7 float waits on older reader", iss_valid[1], 0);
        chk(iss_br == a[4], "R4 branch routing", iss_br, a[4]);
        step(1'b0, 1'b0, '0, 3'b000, 3'b000, '0);
        chk(iss_int == a[0] && iss_valid[0], "R5 hold without ready", iss_int, a[0]);
        step(1'b0, 1'b0, '0, 3'b001, 3'b000, '0);
        chk(iss_int == a[2], "R6/R8 younger overtakes blocked reader", iss_int, a[2]);
        chk(iss_fp == a[3] && iss_valid[1], "R7 float freed", iss_fp, a[3]);
        step(1'b0, 1'b0, '0, 3'b000, 3'b001, 15'(1));
        chk(iss_int == a[1], "R9 completion unblocks", iss_int, a[1]);

        for (int c = 0; c < 4000; c++) begin
            logic [8*INSTR_W-1:0] blk;
            logic [2:0]           cv;
            logic [3*REG_W-1:0]   cr;
            for (int b = 0; b < 8; b++) blk[b*INSTR_W +: INSTR_W] = rnd_instr();
            for (int i = 0; i < 3; i++) begin
                int r = $urandom % 8;
                cr[i*REG_W +: REG_W] = REG_W'(r);
                cv[i] = msb[r] && ($urandom % 2 == 1);
            end
            step(($urandom % 80) == 0, ($urandom % 2) == 1, blk, 3'($urandom % 8), cv, cr);
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule